// File: doc/BRIEF.md
# Single-Bank SDRAM Command Timing Sequencer

This block turns read and write requests for one SDRAM bank into a legal stream of ACTIVATE, READ, WRITE, PRECHARGE and REFRESH strobes. It issues at most one command per clock. Every command goes out in the earliest cycle that the programmed timing allows. Down-counters enforce the spacing rules: row activate to column command (tRCD), activate to precharge (tRAS), activate or refresh to the next activate or refresh (tRC), and precharge to activate or refresh (tRP). After every READ, the block raises a read-data-valid pulse once the programmed CAS latency has passed.

An 8-bit control register sets all of this timing, and it also selects the page policy. Under the open-page policy a row stays open after an access. A later request to the same row then goes straight to a column command, while a request to any other row first closes the open one. Under the closed-page policy the row is precharged after every access. A requester holds its request steady until the block answers with the accept pulse. A refresh request is held until the REFRESH strobe appears, and it always wins over waiting accesses. The address outputs follow the request address; they matter on ACTIVATE (row) and on READ or WRITE (column).

Top module: `sdram_cmd_seq`

## Requirements
- R1: Out of reset, the control register reads 0x17 and no command strobe is active while no request is pending.
- R2: The control register fields are: bit 4 page policy (0 keep open, 1 close after each access), bit 3 delay override, bit 2 CAS latency, bit 1 row timing, bit 0 precharge timing. Bits 7:5 ignore writes and read as 0.
- R3: A register write has effect only while no row is open and the sequencer is idle. A write at any other time leaves the register unchanged.
- R4: A READ or WRITE comes exactly tRCD cycles after its ACTIVATE. tRCD is the CAS latency (2 if bit 2 is 0, 3 if it is 1) when bit 3 is 0, and it is 2 when bit 3 is 1.
- R5: rdValid is high exactly CL cycles after each READ strobe and at no other time.
- R6: PRECHARGE never comes earlier than tRAS cycles after the last ACTIVATE, where tRAS is 5 when bit 1 is 0 and 7 when bit 1 is 1. When nothing else holds it back, it comes exactly then.
- R7: ACTIVATE or REFRESH never comes earlier than tRC cycles after the previous ACTIVATE or REFRESH, where tRC is 8 when bit 1 is 0 and 10 when bit 1 is 1. When nothing else holds it back, it comes exactly then.
- R8: ACTIVATE or REFRESH never comes earlier than tRP cycles after a PRECHARGE, where tRP is 2 when bit 0 is 0 and 3 when bit 0 is 1.
- R9: Under the open-page policy, a request to the open row issues its column command without a new ACTIVATE. A request to another row issues PRECHARGE, then ACTIVATE, then the column command.
- R10: Under the closed-page policy, PRECHARGE follows each access at the earliest cycle that tRAS allows.
- R11: While a refresh request is pending, no ACTIVATE, READ or WRITE is issued. An open row is precharged, and REFRESH follows once tRP and tRC are both met.
- R12: At most one command strobe is high in any cycle, and reqAccept is high exactly in the cycles carrying READ or WRITE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request pending, held until reqAccept |
| reqWrite | input | 1 | 1 for a write request, 0 for a read |
| reqRow | input | ROW_W | Row address of the request |
| reqCol | input | COL_W | Column address of the request |
| reqAccept | output | 1 | Request taken, in the cycle of its READ or WRITE |
| refreshReq | input | 1 | Refresh wanted, held until cmdRefresh |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write value |
| cfgRdData | output | 8 | Control register read value |
| cmdActivate | output | 1 | ACTIVATE strobe |
| cmdRead | output | 1 | READ strobe |
| cmdWrite | output | 1 | WRITE strobe |
| cmdPrecharge | output | 1 | PRECHARGE strobe |
| cmdRefresh | output | 1 | REFRESH strobe |
| cmdRow | output | ROW_W | Row address, valid with ACTIVATE |
| cmdCol | output | COL_W | Column address, valid with READ or WRITE |
| rdValid | output | 1 | Read data valid, CL cycles after READ |

## Verification
The assertions assume that a requester keeps reqValid, reqWrite and the address stable from the moment it raises them until reqAccept. They also assume that refreshReq stays high until cmdRefresh, and that the control register only changes while no READ is still waiting on its latency. The stimulus changes inputs only after a clock edge. It drops each request in the cycle after its accept or refresh strobe, and it writes the register only after an idle gap of at least twelve cycles after the last REFRESH. Because of that gap, timing windows that were started under an older setting have already run out when a new setting takes effect.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int REG_W = 8;
  localparam int CFG_W = 5;

  localparam int BIT_PRE_TIMING = 0;
  localparam int BIT_ROW_TIMING = 1;
  localparam int BIT_CAS_LAT    = 2;
  localparam int BIT_RCD_FORCE  = 3;
  localparam int BIT_PAGE_CLOSE = 4;

  localparam int T_CL_SHORT  = 2;
  localparam int T_CL_LONG   = 3;
  localparam int T_RCD_FORCE = 2;
  localparam int T_RAS_SHORT = 5;
  localparam int T_RAS_LONG  = 7;
  localparam int T_RC_SHORT  = 8;
  localparam int T_RC_LONG   = 10;
  localparam int T_RP_SHORT  = 2;
  localparam int T_RP_LONG   = 3;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic refr;
  } cmd_strobe_t;

  typedef struct packed {
    logic rcdDone;
    logic rasDone;
    logic rcDone;
    logic rpDone;
    logic rowHit;
    logic closeMode;
  } dp_status_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_CLOSE = 2'd2
  } seq_state_t;

endpackage

// File: rtl/seq_down_counter.sv
module seq_down_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         done
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign done = (count == '0);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int         ROW_W     = 13,
  parameter logic [7:0] CFG_RESET = 8'h17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_strobe_t      strobe,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             cfgAllow,
  output logic [REG_W-1:0] cfgRdData,
  output dp_status_t       status,
  output logic             rdValid
);

  localparam int CNT_W   = $clog2(T_RC_LONG + 1);
  localparam int SINCE_W = CNT_W + 1;
  localparam int NUM_TMR = 4;
  localparam int TMR_RCD = 0;
  localparam int TMR_RAS = 1;
  localparam int TMR_RC  = 2;
  localparam int TMR_RP  = 3;
  localparam int PIPE_D  = T_CL_LONG;

  logic [CFG_W-1:0] cfgReg;
  logic             unusedResBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg <= CFG_RESET[CFG_W-1:0];
    end else if (cfgWrEn && cfgAllow) begin
      cfgReg <= cfgWrData[CFG_W-1:0];
    end
  end

  assign unusedResBits = ^{cfgWrData[REG_W-1:CFG_W], CFG_RESET[REG_W-1:CFG_W]};
  assign cfgRdData     = {{(REG_W-CFG_W){1'b0}}, cfgReg};

  // Decoded timing values in clock cycles
  logic [CNT_W-1:0] tCl, tRcd, tRas, tRc, tRp;

  always_comb begin
    tCl  = cfgReg[BIT_CAS_LAT]    ? CNT_W'(T_CL_LONG)  : CNT_W'(T_CL_SHORT);
    tRcd = cfgReg[BIT_RCD_FORCE]  ? CNT_W'(T_RCD_FORCE) : tCl;
    tRas = cfgReg[BIT_ROW_TIMING] ? CNT_W'(T_RAS_LONG) : CNT_W'(T_RAS_SHORT);
    tRc  = cfgReg[BIT_ROW_TIMING] ? CNT_W'(T_RC_LONG)  : CNT_W'(T_RC_SHORT);
    tRp  = cfgReg[BIT_PRE_TIMING] ? CNT_W'(T_RP_LONG)  : CNT_W'(T_RP_SHORT);
  end

  // Timing window counters: loaded with T-1 so the gap is exactly T cycles
  logic [NUM_TMR-1:0] tmrLoad;
  logic [NUM_TMR-1:0] tmrDone;
  logic [CNT_W-1:0]   tmrVal [NUM_TMR];

  always_comb begin
    tmrLoad[TMR_RCD] = strobe.act;
    tmrLoad[TMR_RAS] = strobe.act;
    tmrLoad[TMR_RC]  = strobe.act | strobe.refr;
    tmrLoad[TMR_RP]  = strobe.pre;
    tmrVal[TMR_RCD]  = tRcd - CNT_W'(1);
    tmrVal[TMR_RAS]  = tRas - CNT_W'(1);
    tmrVal[TMR_RC]   = tRc - CNT_W'(1);
    tmrVal[TMR_RP]   = tRp - CNT_W'(1);
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    seq_down_counter #(.W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmrLoad[gi]),
      .loadVal (tmrVal[gi]),
      .done    (tmrDone[gi])
    );
  end

  // Open row tracking
  logic [ROW_W-1:0] openRow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      openRow <= '0;
    end else if (strobe.act) begin
      openRow <= reqRow;
    end
  end

  always_comb begin
    status.rcdDone   = tmrDone[TMR_RCD];
    status.rasDone   = tmrDone[TMR_RAS];
    status.rcDone    = tmrDone[TMR_RC];
    status.rpDone    = tmrDone[TMR_RP];
    status.rowHit    = (openRow == reqRow);
    status.closeMode = cfgReg[BIT_PAGE_CLOSE];
  end

  // Read-valid delay line, tapped by CAS latency
  logic [PIPE_D-1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPipe <= '0;
    end else begin
      rdPipe <= {rdPipe[PIPE_D-2:0], strobe.rd};
    end
  end

  assign rdValid = (tCl == CNT_W'(T_CL_LONG)) ? rdPipe[T_CL_LONG-1] : rdPipe[T_CL_SHORT-1];

  // Independent elapsed-cycle trackers used by the assertions
  logic [SINCE_W-1:0] sinceAct, sinceActRef, sincePre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceAct    <= '1;
      sinceActRef <= '1;
      sincePre    <= '1;
    end else begin
      sinceAct    <= strobe.act ? SINCE_W'(1)
                   : ((sinceAct == '1) ? sinceAct : sinceAct + 1'b1);
      sinceActRef <= (strobe.act || strobe.refr) ? SINCE_W'(1)
                   : ((sinceActRef == '1) ? sinceActRef : sinceActRef + 1'b1);
      sincePre    <= strobe.pre ? SINCE_W'(1)
                   : ((sincePre == '1) ? sincePre : sincePre + 1'b1);
    end
  end

  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rd || strobe.wr) |-> (sinceAct >= {1'b0, tRcd}));

  assert_ras_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pre |-> (sinceAct >= {1'b0, tRas}));

  assert_rc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.act || strobe.refr) |-> (sinceActRef >= {1'b0, tRc}));

  assert_rp_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.act || strobe.refr) |-> (sincePre >= {1'b0, tRp}));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !cfgAllow) |=> $stable(cfgReg));

  assert_rdvalid_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> ((tCl == CNT_W'(T_CL_LONG)) ? $past(strobe.rd, 3) : $past(strobe.rd, 2)));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import sdram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        refreshReq,
  input  dp_status_t  status,
  output cmd_strobe_t strobe,
  output logic        reqAccept,
  output logic        cfgAllow
);

  seq_state_t state, stateNext;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (refreshReq) begin
          strobe.refr = status.rpDone && status.rcDone;
        end else if (reqValid) begin
          strobe.act = status.rpDone && status.rcDone;
        end
      end
      ST_OPEN: begin
        if (refreshReq) begin
          strobe.pre = status.rasDone;
        end else if (reqValid) begin
          if (status.rowHit) begin
            strobe.rd = status.rcdDone && !reqWrite;
            strobe.wr = status.rcdDone && reqWrite;
          end else begin
            strobe.pre = status.rasDone;
          end
        end
      end
      ST_CLOSE: begin
        strobe.pre = status.rasDone;
      end
      default: strobe = '0;
    endcase
  end

  always_comb begin
    stateNext = state;
    if (strobe.act) begin
      stateNext = ST_OPEN;
    end else if (strobe.pre) begin
      stateNext = ST_IDLE;
    end else if ((strobe.rd || strobe.wr) && status.closeMode) begin
      stateNext = ST_CLOSE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign reqAccept = strobe.rd | strobe.wr;
  assign cfgAllow  = (state == ST_IDLE);

  assert_one_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.act, strobe.rd, strobe.wr, strobe.pre, strobe.refr}));

  assert_refresh_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refreshReq |-> !(strobe.act || strobe.rd || strobe.wr));

  assert_col_needs_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rd || strobe.wr) |-> (state == ST_OPEN));

  assert_close_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe.rd || strobe.wr) && status.closeMode) |=> (state == ST_CLOSE));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int         ROW_W     = 13,
  parameter int         COL_W     = 10,
  parameter logic [7:0] CFG_RESET = 8'h17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  output logic             reqAccept,
  input  logic             refreshReq,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  output logic [7:0]       cfgRdData,
  output logic             cmdActivate,
  output logic             cmdRead,
  output logic             cmdWrite,
  output logic             cmdPrecharge,
  output logic             cmdRefresh,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             rdValid
);

  cmd_strobe_t strobe;
  dp_status_t  status;
  logic        cfgAllow;

  seq_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .refreshReq (refreshReq),
    .status     (status),
    .strobe     (strobe),
    .reqAccept  (reqAccept),
    .cfgAllow   (cfgAllow)
  );

  seq_datapath #(
    .ROW_W     (ROW_W),
    .CFG_RESET (CFG_RESET)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqRow    (reqRow),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgAllow  (cfgAllow),
    .cfgRdData (cfgRdData),
    .status    (status),
    .rdValid   (rdValid)
  );

  assign cmdActivate  = strobe.act;
  assign cmdRead      = strobe.rd;
  assign cmdWrite     = strobe.wr;
  assign cmdPrecharge = strobe.pre;
  assign cmdRefresh   = strobe.refr;
  assign cmdRow       = reqRow;
  assign cmdCol       = reqCol;

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;

  localparam int RW = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic          reqAccept, refreshReq = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [7:0]    cfgWrData = '0, cfgRdData;
  logic          cmdActivate, cmdRead, cmdWrite, cmdPrecharge, cmdRefresh, rdValid;
  logic [RW-1:0] cmdRow;
  logic [CW-1:0] cmdCol;

  always #10 clk = ~clk;

  sdram_cmd_seq #(.ROW_W(RW), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqAccept(reqAccept),
    .refreshReq(refreshReq), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cmdActivate(cmdActivate), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .cmdPrecharge(cmdPrecharge), .cmdRefresh(cmdRefresh),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .rdValid(rdValid)
  );

  int   cyc = 0, nChecks = 0, nFails = 0;
  bit   started = 1'b0;
  logic [4:0] curCfg = 5'h17;

  function automatic int fCl(input logic [4:0] v);  return v[2] ? 3 : 2; endfunction
  function automatic int fRcd(input logic [4:0] v); return v[3] ? 2 : fCl(v); endfunction
  function automatic int fRas(input logic [4:0] v); return v[1] ? 7 : 5; endfunction
  function automatic int fRc(input logic [4:0] v);  return v[1] ? 10 : 8; endfunction
  function automatic int fRp(input logic [4:0] v);  return v[0] ? 3 : 2; endfunction
  function automatic int fMax(input int a, input int b); return (a > b) ? a : b; endfunction

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  // Command log and running timing checks
  int lastAct = -1000, lastPre = -1000, lastAR = -1000, lastRef = -1000;
  int lastRd = -1000, lastWr = -1000;
  int nAct = 0, nPre = 0, nRef = 0, nRd = 0, nWr = 0, nRdAtRef = 0;
  bit readAt [16];

  always @(negedge clk) begin
    int k;
    int idx;
    if (started) begin
      k = int'(cmdActivate) + int'(cmdRead) + int'(cmdWrite) + int'(cmdPrecharge) + int'(cmdRefresh);
      chk(k <= 1, "R12 one command", k, 1);
      chk(reqAccept == (cmdRead | cmdWrite), "R12 accept", int'(reqAccept), int'(cmdRead | cmdWrite));
      if (cmdActivate || cmdRefresh) begin
        chk(cyc - lastPre >= fRp(curCfg), "R8 gap", cyc - lastPre, fRp(curCfg));
        chk(cyc - lastAR >= fRc(curCfg), "R7 gap", cyc - lastAR, fRc(curCfg));
        lastAR = cyc;
      end
      if (cmdActivate) begin lastAct = cyc; nAct++; end
      if (cmdRefresh) begin lastRef = cyc; nRef++; nRdAtRef = nRd; end
      if (cmdRead || cmdWrite) begin
        chk(cyc - lastAct >= fRcd(curCfg), "R4 gap", cyc - lastAct, fRcd(curCfg));
        if (cmdRead) begin lastRd = cyc; nRd++; end
        else begin lastWr = cyc; nWr++; end
      end
      if (cmdPrecharge) begin
        chk(cyc - lastAct >= fRas(curCfg), "R6 gap", cyc - lastAct, fRas(curCfg));
        lastPre = cyc; nPre++;
      end
      idx = (cyc - fCl(curCfg)) & 15;
      chk(rdValid == readAt[idx], "R5 rdValid", int'(rdValid), int'(readAt[idx]));
      readAt[idx] = 1'b0;
      readAt[cyc & 15] = cmdRead;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic cfgWr(input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic issueReq(input bit wr, input int row, input int col, output int s);
    s = cyc;
    reqValid = 1'b1; reqWrite = wr; reqRow = RW'(row); reqCol = CW'(col);
    forever begin
      @(negedge clk); #1;
      if (reqAccept) break;
      if (cmdRefresh) begin tick(); refreshReq = 1'b0; end
    end
    tick();
    reqValid = 1'b0;
  endtask

  task automatic doRefresh(output int s);
    s = cyc;
    refreshReq = 1'b1;
    do begin @(negedge clk); #1; end while (!cmdRefresh);
    tick();
    refreshReq = 1'b0;
  endtask

  task automatic runCfg(input int c);
    int s, a1, aL, aE, rdB, nA0, tgt, r1, r2;
    logic [4:0] cv;
    cv = c[4:0];
    repeat (12) tick();
    cfgWr({3'b111, cv});
    chk(cfgRdData == {3'b000, cv}, "R2 readback", int'(cfgRdData), int'({3'b000, cv}));
    curCfg = cv;
    r1 = c % 15; r2 = r1 + 1;

    issueReq(1'b0, r1, c, s);
    a1 = lastAct;
    chk(lastRd - a1 == fRcd(cv), "R4 act-to-read", lastRd - a1, fRcd(cv));

    if (cv[4]) begin
      tgt = nPre + 1;
      while (nPre < tgt) tick();
      chk(lastPre == a1 + fRas(cv), "R10 auto close", lastPre, a1 + fRas(cv));
      issueReq(1'b1, r1, c + 1, s);
      chk(lastAct == fMax(s, fMax(lastPre + fRp(cv), a1 + fRc(cv))), "R8 reopen", lastAct,
          fMax(s, fMax(lastPre + fRp(cv), a1 + fRc(cv))));
      chk(lastWr - lastAct == fRcd(cv), "R4 act-to-write", lastWr - lastAct, fRcd(cv));
    end else begin
      nA0 = nAct;
      issueReq(1'b1, r1, c + 1, s);
      chk(nAct == nA0, "R9 row hit", nAct, nA0);
      cfgWr({3'b000, ~cv});
      chk(cfgRdData == {3'b000, cv}, "R3 write while open", int'(cfgRdData), int'({3'b000, cv}));
      issueReq(1'b0, r2, c + 2, s);
      chk(lastPre == fMax(a1 + fRas(cv), s), "R9 miss precharge", lastPre, fMax(a1 + fRas(cv), s));
      chk(lastAct == fMax(lastPre + fRp(cv), a1 + fRc(cv)), "R7 miss activate", lastAct,
          fMax(lastPre + fRp(cv), a1 + fRc(cv)));
      chk(lastRd - lastAct == fRcd(cv), "R4 miss read", lastRd - lastAct, fRcd(cv));
    end

    aL = lastAct; rdB = nRd;
    refreshReq = 1'b1;
    issueReq(1'b0, cv[4] ? r1 : r2, c + 3, s);
    chk(lastPre == fMax(aL + fRas(cv), s), "R11 precharge", lastPre, fMax(aL + fRas(cv), s));
    chk(lastRef == fMax(lastPre + fRp(cv), aL + fRc(cv)), "R11 refresh", lastRef,
        fMax(lastPre + fRp(cv), aL + fRc(cv)));
    chk(nRdAtRef == rdB, "R11 access held", nRdAtRef, rdB);
    chk(lastAct == lastRef + fRc(cv), "R7 refresh-to-act", lastAct, lastRef + fRc(cv));
    chk(lastRd - lastAct == fRcd(cv), "R4 after refresh", lastRd - lastAct, fRcd(cv));

    aE = lastAct;
    doRefresh(s);
    chk(lastPre == fMax(aE + fRas(cv), s), cv[4] ? "R10 close" : "R6 precharge", lastPre,
        fMax(aE + fRas(cv), s));
    chk(lastRef == fMax(lastPre + fRp(cv), aE + fRc(cv)), "R8 refresh", lastRef,
        fMax(lastPre + fRp(cv), aE + fRc(cv)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cfgRdData == 8'h17, "R1 reset value", int'(cfgRdData), 'h17);
    tick();
    rst_n = 1'b1;
    started = 1'b1;
    tick();
    @(negedge clk);
    chk(cfgRdData == 8'h17, "R1 after reset", int'(cfgRdData), 'h17);
    chk({cmdActivate, cmdRead, cmdWrite, cmdPrecharge, cmdRefresh} == 5'b0, "R1 no command",
        int'({cmdActivate, cmdRead, cmdWrite, cmdPrecharge, cmdRefresh}), 0);
    tick();
    for (int c = 0; c < 32; c++) runCfg(c);
    repeat (10) tick();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule